// File: doc/BRIEF.md
# Interrupt Lifecycle State Tracker

This block holds the pending and active state of every interrupt in a bank that mixes four kinds of source: software-generated interrupts, private peripheral interrupts, shared peripheral interrupts and message-based interrupts. Each interrupt is in one of four states: inactive, pending, active, or active-and-pending. State changes come from the registered interrupt lines, from software set-pending and clear-pending pulse vectors, and from acknowledge, end-of-interrupt and deactivate operations that each carry an interrupt index. The resulting pending and active vectors drive a prioritizer that sits outside this block.

The state after an acknowledge depends on how the interrupt is triggered. For an edge-triggered interrupt the pending flag is consumed by the acknowledge. A new edge seen in the acknowledge cycle or later makes the interrupt pending again. A level-sensitive interrupt stays pending as long as its line is held high. Message-based interrupts never hold an active state, so an acknowledge only consumes their pending flag. A global mode input selects between two schemes. In combined mode the end-of-interrupt operation also deactivates. In split mode only the separate deactivate operation removes the active state.

Indices are laid out by kind: software-generated from 0, then private, then shared, then message-based. With the default parameters these are 0-3, 4-7, 8-15 and 16-19.

Top module: `irq_life_tracker`

## Requirements
- R1: After reset every bit of `pend_o` and `act_o` is 0.
- R2: For an edge-triggered private or shared interrupt (`trig_level` bit = 0), a 0-to-1 change of its line makes `pend_o` go high two rising clock edges after the change is sampled. It stays high after the line falls.
- R3: For a level-sensitive private or shared interrupt (`trig_level` bit = 1), `pend_o` follows the line with a two-edge delay. Pending is removed when the line deasserts, whether or not the interrupt is active.
- R4: A `sw_set` pulse makes the interrupt pending on the next edge and a `sw_clr` pulse removes pending. When both arrive in the same cycle, set wins.
- R5: Acknowledging a pending edge-triggered interrupt makes it active and not pending. A set event (new edge or `sw_set`) in the acknowledge cycle or later makes it active-and-pending.
- R6: Acknowledging a pending level-sensitive interrupt makes it active-and-pending while the registered line is high, and active only when the line is low.
- R7: An acknowledge that names an interrupt that is not pending, or an index of `N_IRQ` or above, changes nothing.
- R8: Deactivation removes the active state and leaves the pending state unchanged.
- R9: With `split_mode` = 0, an end-of-interrupt deactivates the named interrupt and a deactivate operation is ignored.
- R10: With `split_mode` = 1, an end-of-interrupt changes no state and a deactivate operation deactivates the named interrupt.
- R11: A deactivation aimed at an interrupt that is not active is ignored.
- R12: Software-generated interrupts are always edge-triggered: their `trig_level` bit and their line are ignored, and only `sw_set` makes them pending.
- R13: A message-based interrupt becomes pending on a rising line, ignores its `trig_level` bit, and is never active. An acknowledge only clears its pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_mode | input | 1 | 0: end-of-interrupt deactivates; 1: deactivation is a separate operation |
| trig_level | input | N_IRQ | Per-interrupt trigger type, 1 = level-sensitive |
| src_line | input | N_IRQ | Raw interrupt lines |
| sw_set | input | N_IRQ | Software set-pending pulses |
| sw_clr | input | N_IRQ | Software clear-pending pulses |
| ack_vld | input | 1 | Acknowledge operation valid |
| ack_id | input | IDW | Acknowledged interrupt index |
| eoi_vld | input | 1 | End-of-interrupt operation valid |
| eoi_id | input | IDW | End-of-interrupt index |
| dir_vld | input | 1 | Deactivate operation valid |
| dir_id | input | IDW | Deactivated interrupt index |
| pend_o | output | N_IRQ | Pending vector |
| act_o | output | N_IRQ | Active vector |

## Verification
Each interrupt's state is a two-bit register that drives the outputs directly, so a wrong transition shows on `pend_o` or `act_o` one edge after the offending operation, or two edges after a line change. A stuck or wrongly cleared active bit persists until the next deactivation, so the bench checks every step before the following operation can mask it. The riskiest cases are the same-cycle collisions: an edge together with an acknowledge, set together with clear, and deactivate together with leftover pending. Each of these collisions is checked bit-exactly at the named index.

// File: rtl/irq_life_pkg.sv
package irq_life_pkg;

  typedef enum logic [1:0] {
    K_SGI  = 2'd0,
    K_PRIV = 2'd1,
    K_SHR  = 2'd2,
    K_MSG  = 2'd3
  } irq_kind_e;

  // Kind of an interrupt from its index in the bank layout.
  function automatic irq_kind_e kind_of(input int idx, input int n_sgi,
                                        input int n_priv, input int n_shr);
    if (idx < n_sgi)                       return K_SGI;
    else if (idx < n_sgi + n_priv)         return K_PRIV;
    else if (idx < n_sgi + n_priv + n_shr) return K_SHR;
    else                                   return K_MSG;
  endfunction

  // Only private and shared interrupts may be level-sensitive.
  function automatic logic eff_level(input irq_kind_e k, input logic cfg);
    return cfg && (k == K_PRIV || k == K_SHR);
  endfunction

  // Software-generated interrupts have no line.
  function automatic logic uses_line(input irq_kind_e k);
    return k != K_SGI;
  endfunction

  // Message-based interrupts never hold an active state.
  function automatic logic keeps_active(input irq_kind_e k);
    return k != K_MSG;
  endfunction

  // Next {pending, active} from the events of this cycle.
  function automatic logic [1:0] next_state(input logic holds_act,
                                            input logic set_ev,
                                            input logic clr_ev,
                                            input logic ack_hit,
                                            input logic deact_hit,
                                            input logic pend,
                                            input logic act);
    logic pn, an;
    if (ack_hit) begin
      pn = set_ev;
      an = holds_act;
    end else begin
      pn = set_ev | (pend & ~clr_ev);
      an = act & ~deact_hit;
    end
    return {pn, an};
  endfunction

endpackage

// File: rtl/irq_src_stage.sv
module irq_src_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= '0;
      q2 <= '0;
    end else begin
      q1 <= line_i;
      q2 <= q1;
    end
  end

  assign lvl_o  = q1;
  assign rise_o = q1 & ~q2;
  assign fall_o = ~q1 & q2;

endmodule

// File: rtl/irq_op_decode.sv
module irq_op_decode #(
  parameter int N   = 8,
  parameter int IDW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           split_mode,
  input  logic           ack_vld,
  input  logic [IDW-1:0] ack_id,
  input  logic           eoi_vld,
  input  logic [IDW-1:0] eoi_id,
  input  logic           dir_vld,
  input  logic [IDW-1:0] dir_id,
  output logic [N-1:0]   ack_oh,
  output logic [N-1:0]   deact_oh
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    logic eoi_hit, dir_hit;
    assign ack_oh[i]   = ack_vld && (ack_id == IDW'(i));
    assign eoi_hit     = eoi_vld && (eoi_id == IDW'(i));
    assign dir_hit     = dir_vld && (dir_id == IDW'(i));
    assign deact_oh[i] = split_mode ? dir_hit : eoi_hit;
  end

  // R7: at most one interrupt is acknowledged per cycle
  p_one_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_oh));

  // R9: in combined mode a lone deactivate operation selects nothing
  p_dir_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_mode && !eoi_vld) |-> (deact_oh == '0));

  // R10: in split mode a lone end-of-interrupt selects nothing
  p_eoi_no_deact_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (split_mode && !dir_vld) |-> (deact_oh == '0));

endmodule

// File: rtl/irq_state_cell.sv
module irq_state_cell
  import irq_life_pkg::*;
#(
  parameter irq_kind_e KIND = K_SHR
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_cfg,
  input  logic lvl,
  input  logic rise,
  input  logic fall,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic ack_sel,
  input  logic deact_sel,
  output logic pend,
  output logic act
);
  logic pend_q, act_q;
  logic is_lvl, use_line, set_ev, clr_ev, ack_hit, deact_hit;
  logic [1:0] nxt;

  assign is_lvl    = eff_level(KIND, level_cfg);
  assign use_line  = uses_line(KIND);
  assign set_ev    = sw_set | (use_line & (is_lvl ? lvl : rise));
  assign clr_ev    = sw_clr | (use_line & is_lvl & fall);
  assign ack_hit   = ack_sel & pend_q;
  assign deact_hit = deact_sel & act_q;
  assign nxt       = next_state(keeps_active(KIND), set_ev, clr_ev,
                                ack_hit, deact_hit, pend_q, act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      pend_q <= nxt[1];
      act_q  <= nxt[0];
    end
  end

  assign pend = pend_q;
  assign act  = act_q;

  // R5: edge acknowledge with no new set event -> active only
  p_edge_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !is_lvl && KIND != K_MSG && !set_ev) |=> (act_q && !pend_q));

  // R5: set event in the acknowledge cycle -> active-and-pending
  p_edge_reack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && KIND != K_MSG && set_ev) |=> (act_q && pend_q));

  // R6: level acknowledge with line held -> active-and-pending
  p_level_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && is_lvl && lvl) |=> (act_q && pend_q));

  // R8: deactivation keeps pending untouched
  p_deact_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_hit && !ack_hit && !set_ev && !clr_ev) |=> (!act_q && $stable(pend_q)));

  // R11: deactivation of an inactive interrupt leaves it inactive
  p_ignore_deact_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_sel && !act_q && !ack_hit) |=> !act_q);

  // R7: acknowledge of a non-pending interrupt changes nothing
  p_ack_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_sel && !pend_q && !set_ev && !deact_hit) |=> ($stable(pend_q) && $stable(act_q)));

  if (KIND == K_MSG) begin : g_msg_chk
    // R13: message acknowledge only consumes pending
    p_msg_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !set_ev) |=> (!pend_q && !act_q));
  end

  if (KIND == K_SGI) begin : g_sgi_chk
    // R12: without a software set, a software-generated interrupt stays idle
    p_sgi_no_line_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && !sw_set) |=> !pend_q);
  end

endmodule

// File: rtl/irq_life_tracker.sv
module irq_life_tracker
  import irq_life_pkg::*;
#(
  parameter int N_SGI  = 4,
  parameter int N_PRIV = 4,
  parameter int N_SHR  = 8,
  parameter int N_MSG  = 4,
  localparam int N_IRQ = N_SGI + N_PRIV + N_SHR + N_MSG,
  localparam int IDW   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split_mode,
  input  logic [N_IRQ-1:0] trig_level,
  input  logic [N_IRQ-1:0] src_line,
  input  logic [N_IRQ-1:0] sw_set,
  input  logic [N_IRQ-1:0] sw_clr,
  input  logic             ack_vld,
  input  logic [IDW-1:0]   ack_id,
  input  logic             eoi_vld,
  input  logic [IDW-1:0]   eoi_id,
  input  logic             dir_vld,
  input  logic [IDW-1:0]   dir_id,
  output logic [N_IRQ-1:0] pend_o,
  output logic [N_IRQ-1:0] act_o
);
  logic [N_IRQ-1:0] lvl, rise, fall, ack_oh, deact_oh;

  irq_src_stage #(.W(N_IRQ)) u_src (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (src_line),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  irq_op_decode #(.N(N_IRQ), .IDW(IDW)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .split_mode (split_mode),
    .ack_vld    (ack_vld),
    .ack_id     (ack_id),
    .eoi_vld    (eoi_vld),
    .eoi_id     (eoi_id),
    .dir_vld    (dir_vld),
    .dir_id     (dir_id),
    .ack_oh     (ack_oh),
    .deact_oh   (deact_oh)
  );

  for (genvar i = 0; i < N_IRQ; i++) begin : g_cell
    localparam irq_kind_e K = kind_of(i, N_SGI, N_PRIV, N_SHR);
    irq_state_cell #(.KIND(K)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_cfg (trig_level[i]),
      .lvl       (lvl[i]),
      .rise      (rise[i]),
      .fall      (fall[i]),
      .sw_set    (sw_set[i]),
      .sw_clr    (sw_clr[i]),
      .ack_sel   (ack_oh[i]),
      .deact_sel (deact_oh[i]),
      .pend      (pend_o[i]),
      .act       (act_o[i])
    );
  end

  // R13: message-based interrupts never show active
  if (N_MSG > 0) begin : g_msg_top
    p_msg_inactive_r13: assert property (@(posedge clk) disable iff (!rst_n)
      act_o[N_IRQ-1 -: N_MSG] == '0);
  end

  // R1: state is clear in the first cycle out of reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pend_o == '0 && act_o == '0));

endmodule

// File: tb/irq_life_tracker_bench.sv
module irq_life_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 20;
  localparam int IDW = 5;

  localparam logic [3:0] OP_SET = 4'd0, OP_CLR = 4'd1, OP_ACK = 4'd2,
                         OP_EOI = 4'd3, OP_DIR = 4'd4, OP_SRCH = 4'd5,
                         OP_SRCL = 4'd6, OP_TLVL = 4'd7, OP_SPLIT = 4'd8,
                         OP_COMB = 4'd9;

  // {op, index, expected pending, expected active, requirement number}
  localparam int NV = 33;
  localparam logic [14:0] VEC [NV] = '{
    {OP_SET,   5'd0,  1'b1, 1'b0, 4'd4},   // R4 set
    {OP_ACK,   5'd0,  1'b0, 1'b1, 4'd5},   // R5 pending -> active
    {OP_SET,   5'd0,  1'b1, 1'b1, 4'd5},   // R5 active-and-pending
    {OP_DIR,   5'd0,  1'b1, 1'b1, 4'd9},   // R9 dir ignored, combined
    {OP_EOI,   5'd0,  1'b1, 1'b0, 4'd9},   // R9 eoi deactivates
    {OP_CLR,   5'd0,  1'b0, 1'b0, 4'd4},   // R4 clear
    {OP_ACK,   5'd0,  1'b0, 1'b0, 4'd7},   // R7 ack of idle
    {OP_EOI,   5'd0,  1'b0, 1'b0, 4'd11},  // R11 deact of inactive
    {OP_SRCH,  5'd8,  1'b1, 1'b0, 4'd2},   // R2 edge sets pending
    {OP_SRCL,  5'd8,  1'b1, 1'b0, 4'd2},   // R2 stays pending
    {OP_ACK,   5'd8,  1'b0, 1'b1, 4'd5},   // R5
    {OP_SPLIT, 5'd8,  1'b0, 1'b1, 4'd10},  // R10 mode change keeps state
    {OP_EOI,   5'd8,  1'b0, 1'b1, 4'd10},  // R10 eoi no effect
    {OP_DIR,   5'd8,  1'b0, 1'b0, 4'd10},  // R10 dir deactivates
    {OP_TLVL,  5'd9,  1'b0, 1'b0, 4'd3},   // R3
    {OP_SRCH,  5'd9,  1'b1, 1'b0, 4'd3},   // R3 level pending
    {OP_ACK,   5'd9,  1'b1, 1'b1, 4'd6},   // R6 held line
    {OP_SRCL,  5'd9,  1'b0, 1'b1, 4'd3},   // R3 deassert removes pending
    {OP_DIR,   5'd9,  1'b0, 1'b0, 4'd8},   // R8
    {OP_SET,   5'd9,  1'b1, 1'b0, 4'd4},   // R4 sw set on level
    {OP_ACK,   5'd9,  1'b0, 1'b1, 4'd6},   // R6 line low
    {OP_DIR,   5'd9,  1'b0, 1'b0, 4'd10},  // R10
    {OP_TLVL,  5'd1,  1'b0, 1'b0, 4'd12},  // R12
    {OP_SRCH,  5'd1,  1'b0, 1'b0, 4'd12},  // R12 line ignored
    {OP_SET,   5'd1,  1'b1, 1'b0, 4'd12},  // R12
    {OP_ACK,   5'd1,  1'b0, 1'b1, 4'd12},  // R12 edge behaviour
    {OP_DIR,   5'd1,  1'b0, 1'b0, 4'd12},  // R12
    {OP_TLVL,  5'd16, 1'b0, 1'b0, 4'd13},  // R13
    {OP_SRCH,  5'd16, 1'b1, 1'b0, 4'd13},  // R13 rise
    {OP_ACK,   5'd16, 1'b0, 1'b0, 4'd13},  // R13 never active
    {OP_DIR,   5'd16, 1'b0, 1'b0, 4'd11},  // R11
    {OP_SRCL,  5'd16, 1'b0, 1'b0, 4'd13},  // R13
    {OP_SRCL,  5'd1,  1'b0, 1'b0, 4'd12}   // R12
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic split_mode = 1'b0;
  logic [N-1:0] trig_level = '0, src_line = '0, sw_set = '0, sw_clr = '0;
  logic ack_vld = 1'b0, eoi_vld = 1'b0, dir_vld = 1'b0;
  logic [IDW-1:0] ack_id = '0, eoi_id = '0, dir_id = '0;
  logic [N-1:0] pend_o, act_o;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_life_tracker u_irq_life_tracker (
    .clk(clk), .rst_n(rst_n), .split_mode(split_mode),
    .trig_level(trig_level), .src_line(src_line),
    .sw_set(sw_set), .sw_clr(sw_clr),
    .ack_vld(ack_vld), .ack_id(ack_id),
    .eoi_vld(eoi_vld), .eoi_id(eoi_id),
    .dir_vld(dir_vld), .dir_id(dir_id),
    .pend_o(pend_o), .act_o(act_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check_bit(input int idx, input logic ep, input logic ea, input int req);
    checks++;
    if (pend_o[idx] !== ep || act_o[idx] !== ea) begin
      errors++;
      $display("FAIL R%0d idx %0d: pend/act actual %b/%b expected %b/%b",
               req, idx, pend_o[idx], act_o[idx], ep, ea);
    end
  endtask

  task automatic clear_pulses();
    sw_set = '0; sw_clr = '0;
    ack_vld = 1'b0; eoi_vld = 1'b0; dir_vld = 1'b0;
  endtask

  task automatic do_step(input logic [3:0] op, input int idx);
    @(negedge clk);
    case (op)
      OP_SET:   sw_set[idx] = 1'b1;
      OP_CLR:   sw_clr[idx] = 1'b1;
      OP_ACK:   begin ack_vld = 1'b1; ack_id = IDW'(idx); end
      OP_EOI:   begin eoi_vld = 1'b1; eoi_id = IDW'(idx); end
      OP_DIR:   begin dir_vld = 1'b1; dir_id = IDW'(idx); end
      OP_SRCH:  src_line[idx] = 1'b1;
      OP_SRCL:  src_line[idx] = 1'b0;
      OP_TLVL:  trig_level[idx] = 1'b1;
      OP_SPLIT: split_mode = 1'b1;
      OP_COMB:  split_mode = 1'b0;
      default:  ;
    endcase
    @(negedge clk);
    clear_pulses();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (pend_o !== '0 || act_o !== '0) begin
      errors++;
      $display("FAIL R1: pend/act actual %h/%h expected 0/0", pend_o, act_o);
    end

    for (int v = 0; v < NV; v++) begin
      do_step(VEC[v][14:11], int'(VEC[v][10:6]));
      check_bit(int'(VEC[v][10:6]), VEC[v][5], VEC[v][4], int'(VEC[v][3:0]));
    end

    // R5: edge arriving in the acknowledge cycle -> active-and-pending
    do_step(OP_SET, 4);
    check_bit(4, 1'b1, 1'b0, 4);
    @(negedge clk); src_line[4] = 1'b1;
    @(negedge clk); ack_vld = 1'b1; ack_id = 5'd4;
    @(negedge clk); clear_pulses();
    check_bit(4, 1'b1, 1'b1, 5);
    do_step(OP_DIR, 4);
    check_bit(4, 1'b1, 1'b0, 8);      // R8 pending kept
    do_step(OP_CLR, 4);
    check_bit(4, 1'b0, 1'b0, 4);
    do_step(OP_SRCL, 4);

    // R4: set and clear in one cycle, set wins
    @(negedge clk); sw_set[12] = 1'b1; sw_clr[12] = 1'b1;
    @(negedge clk); clear_pulses();
    check_bit(12, 1'b1, 1'b0, 4);
    do_step(OP_CLR, 12);
    check_bit(12, 1'b0, 1'b0, 4);

    // R7: out-of-range acknowledge index ignored
    do_step(OP_SET, 12);
    @(negedge clk); ack_vld = 1'b1; ack_id = 5'd28;
    @(negedge clk); clear_pulses();
    checks++;
    if (act_o !== '0 || pend_o[12] !== 1'b1) begin
      errors++;
      $display("FAIL R7: act/pend12 actual %h/%b expected 0/1", act_o, pend_o[12]);
    end
    do_step(OP_CLR, 12);

    // R9: back to combined mode
    do_step(OP_COMB, 13);
    do_step(OP_SET, 13);
    do_step(OP_ACK, 13);
    check_bit(13, 1'b0, 1'b1, 5);
    do_step(OP_DIR, 13);
    check_bit(13, 1'b0, 1'b1, 9);
    do_step(OP_EOI, 13);
    check_bit(13, 1'b0, 1'b0, 9);

    // R6/R8/R3: held level, acknowledge, end-of-interrupt keeps pending
    do_step(OP_TLVL, 14);
    do_step(OP_SRCH, 14);
    check_bit(14, 1'b1, 1'b0, 3);
    do_step(OP_ACK, 14);
    check_bit(14, 1'b1, 1'b1, 6);
    do_step(OP_EOI, 14);
    check_bit(14, 1'b1, 1'b0, 8);
    do_step(OP_SRCL, 14);
    check_bit(14, 1'b0, 1'b0, 3);

    // R1: reset clears live state
    do_step(OP_SET, 15);
    do_step(OP_ACK, 15);
    do_step(OP_SET, 15);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    checks++;
    if (pend_o !== '0 || act_o !== '0) begin
      errors++;
      $display("FAIL R1: pend/act after reset actual %h/%h expected 0/0", pend_o, act_o);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule